// File: doc/BRIEF.md
# Consumed-Sample Count Readback Port

This block keeps a running count of the samples that the fabric has actually taken out of a host-to-fabric data FIFO. Host software can then compare the samples it has written with the samples consumed, and work out how much data is still buffered. A sample counts only when the FIFO read side asserts its read strobe while the FIFO holds data. The count is a sample count, so a multi-word burst adds one per word.

The count is presented as the read side of a host-bound 32-bit stream that looks like a FIFO read port. The empty output is tied low, so a host read is never stalled. Each read enable captures the live count into a registered data output, so every 4-byte host read returns one whole, current value. The count clears whenever the monitored stream is closed, so each open session starts from zero. The counter wraps on overflow, and software is expected to use modular subtraction.

Top module: `consumed_count_port`

## Requirements
- R1: While `stream_open` is 1, each clock edge with `fifo_rd_en`=1 and `fifo_empty`=0 adds exactly one to the count.
- R2: A cycle with `fifo_rd_en`=1 and `fifo_empty`=1 does not change the count.
- R3: An edge with `stream_open`=0 sets the count to 0. After reopening, counting resumes from 0.
- R4: When the stream is closed in the same cycle as a qualified consume, the clear wins and the count is 0.
- R5: `rd_empty` is 0 in every cycle, including during reset.
- R6: An edge with `rd_en`=1 loads `rd_data` with the count as it stood before that edge, so a consume in the same cycle is not included. `rd_data` does not change on edges with `rd_en`=0.
- R7: The count wraps modulo 2^CNT_W. `rd_data` carries it zero-extended to 32 bits.
- R8: A synchronous active-high `rst` sets both the count and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_open | input | 1 | 1 while the monitored host-to-fabric stream is open |
| fifo_rd_en | input | 1 | Read strobe on the data FIFO's read side |
| fifo_empty | input | 1 | Empty flag of the data FIFO |
| rd_en | input | 1 | Host-side read request for the count stream |
| rd_data | output | 32 | Registered count snapshot |
| rd_empty | output | 1 | Always 0 |

## Verification
The hardest case to reach is a read that lands in the same cycle as a consume, or in the same cycle as a stream close. That is where the snapshot must hold the value from before the edge, and where the clear must beat the increment. Directed steps place these collisions deliberately. Seeded random stimulus then mixes all four inputs at high toggle rates, so such overlaps recur many times. Reaching a wrap at the default width would take billions of cycles, so a second instance with an 8-bit counter is driven past 256 consumes.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int unsigned CCP_DATA_W = 32;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_CLEAR = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/ccp_consume_qual.sv
module ccp_consume_qual
  import ccp_pkg::*;
(
  input  logic     stream_open,
  input  logic     fifo_rd_en,
  input  logic     fifo_empty,
  output cnt_act_e act
);
  // A closed stream overrides any consume in the same cycle (R4).
  always_comb begin
    if (!stream_open)                    act = ACT_CLEAR;
    else if (fifo_rd_en && !fifo_empty)  act = ACT_STEP;
    else                                 act = ACT_HOLD;
  end
endmodule

// File: rtl/ccp_sample_counter.sv
module ccp_sample_counter
  import ccp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_act_e         act,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      unique case (act)
        ACT_CLEAR: count_q <= '0;
        ACT_STEP:  count_q <= count_q + 1'b1;  // wraps modulo 2^CNT_W (R7)
        default:   count_q <= count_q;
      endcase
    end
  end

  assign count = count_q;

  // R1, R7: one qualified consume adds one, modulo 2^CNT_W
  a_r1_step_one: assert property (@(posedge clk) disable iff (rst)
    act == ACT_STEP |=> count_q == CNT_W'($past(count_q) + 1'b1));
  // R3, R4: a closed-stream edge leaves the count at zero
  a_r3_clear_on_close: assert property (@(posedge clk) disable iff (rst)
    act == ACT_CLEAR |=> count_q == '0);
  // R2: no qualified consume, no change
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    act == ACT_HOLD |=> $stable(count_q));
endmodule

// File: rtl/ccp_snapshot_reg.sv
module ccp_snapshot_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] live,
  output logic [DATA_W-1:0] snap
);
  logic [DATA_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (capture) snap_q <= live;
  end

  assign snap = snap_q;

  // R6: no capture, no change
  a_r6_hold_snapshot: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap_q));
endmodule

// File: rtl/consumed_count_port.sv
module consumed_count_port
  import ccp_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = CCP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stream_open,
  input  logic              fifo_rd_en,
  input  logic              fifo_empty,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  cnt_act_e          act;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] count_ext;

  ccp_consume_qual u_qual (
    .stream_open (stream_open),
    .fifo_rd_en  (fifo_rd_en),
    .fifo_empty  (fifo_empty),
    .act         (act)
  );

  ccp_sample_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .act   (act),
    .count (count)
  );

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count};
    end else begin : g_direct
      assign count_ext = count[DATA_W-1:0];
    end
  endgenerate

  ccp_snapshot_reg #(.DATA_W(DATA_W)) u_snap (
    .clk     (clk),
    .rst     (rst),
    .capture (rd_en),
    .live    (count_ext),
    .snap    (rd_data)
  );

  // The count stream always has a word ready (R5).
  assign rd_empty = 1'b0;

  // R6: a read loads the pre-edge count
  a_r6_capture_live: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(count_ext));
  // R4: close wins over a same-cycle consume
  a_r4_close_priority: assert property (@(posedge clk) disable iff (rst)
    (!stream_open && fifo_rd_en && !fifo_empty) |=> count == '0);
  // R8: reset empties the snapshot
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> rd_data == '0);
endmodule

// File: tb/consumed_count_port_test.sv
module consumed_count_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stream_open = 1'b0, fifo_rd_en = 1'b0, fifo_empty = 1'b1, rd_en = 1'b0;
  logic [31:0] rd_data, rd_data8;
  logic        rd_empty, rd_empty8;

  int unsigned n_tests = 0, n_fail = 0;
  logic [31:0] exp_cnt = '0, exp_data = '0;
  logic [7:0]  exp_cnt8 = '0;
  logic [31:0] exp_data8 = '0;

  always #2.5 clk = ~clk;

  consumed_count_port uut (
    .clk(clk), .rst(rst), .stream_open(stream_open), .fifo_rd_en(fifo_rd_en),
    .fifo_empty(fifo_empty), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty));

  consumed_count_port #(.CNT_W(8)) uut8 (
    .clk(clk), .rst(rst), .stream_open(stream_open), .fifo_rd_en(fifo_rd_en),
    .fifo_empty(fifo_empty), .rd_en(rd_en), .rd_data(rd_data8), .rd_empty(rd_empty8));

  function automatic logic [31:0] next_count(logic [31:0] c, logic o, logic fr, logic fe);
    if (!o)            return 32'd0;
    else if (fr && !fe) return c + 32'd1;
    else               return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, update the model, return at negedge
  task automatic step(input logic r, input logic o, input logic fr, input logic fe, input logic re);
    rst = r; stream_open = o; fifo_rd_en = fr; fifo_empty = fe; rd_en = re;
    @(posedge clk);
    if (r) begin
      exp_cnt = '0; exp_cnt8 = '0; exp_data = '0; exp_data8 = '0;
    end else begin
      if (re) begin
        exp_data  = exp_cnt;
        exp_data8 = {24'd0, exp_cnt8};
      end
      exp_cnt  = next_count(exp_cnt, o, fr, fe);
      exp_cnt8 = 8'(next_count({24'd0, exp_cnt8}, o, fr, fe));
    end
    @(negedge clk);
  endtask

  task automatic read_check(input string req);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    check(req, rd_data, exp_data);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    @(negedge clk);
    check("R5 during reset", {31'd0, rd_empty}, 32'd0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 reset data", rd_data, 32'd0);

    // R1: five consumes
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    read_check("R1 five consumes");
    check("R1 value", rd_data, 32'd5);

    // R2: read attempts on an empty FIFO
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    read_check("R2 empty strobes ignored");
    check("R2 value", rd_data, 32'd5);

    // R6: read together with a consume sees the pre-edge count
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R6 same-cycle read", rd_data, 32'd5);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R6 hold without rd_en", rd_data, 32'd5);
    read_check("R6 later read");
    check("R6 value", rd_data, 32'd9);

    // R4: close coinciding with a consume and a read
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R4 read at close", rd_data, 32'd9);
    read_check("R4 clear wins");
    check("R4 value", rd_data, 32'd0);

    // R3: count, close, reopen
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    read_check("R3 cleared on reopen");
    check("R3 zero", rd_data, 32'd0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    read_check("R3 restart from zero");
    check("R3 value", rd_data, 32'd2);

    // R8: reset mid-session
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R8 reset clears data", rd_data, 32'd0);
    read_check("R8 count cleared");

    // R7: wrap on the 8-bit instance
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    read_check("R7 wide no wrap");
    check("R7 wide value", rd_data, 32'd300);
    check("R7 narrow wrapped", rd_data8, 32'd44);

    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      logic o, fr, fe, re;
      o  = ($urandom % 16) != 0;
      fr = $urandom % 2;
      fe = ($urandom % 4) == 0;
      re = $urandom % 2;
      step(1'b0, o, fr, fe, re);
      check("R6 random wide", rd_data, exp_data);
      check("R7 random narrow", rd_data8, exp_data8);
      if (i % 100 == 0) check("R5 random", {30'd0, rd_empty, rd_empty8}, 32'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule